// File: doc/BRIEF.md
# Serial Control Register Interface

This block receives configuration words from a host controller over a three-wire write port: a data line, a bit clock and a latch strobe. Bits enter a 12-bit shift register, most significant first, one per rising bit-clock edge. A rising edge on the latch strobe commits the word. Its leading bit picks the destination: either an 11-bit attenuation level or a set of seven mode flags.

The mode flags are two test selects, a ratio-check rate bit, a +12 dB gain shift, a two-bit deemphasis sample-rate code and a deemphasis enable. A host-select input decides the source of the deemphasis controls. When it is high they come from the registers. When it is low they come from three direct pins, and the attenuation output is held at unity. All three serial wires are asynchronous to the system clock. They are resynchronised inside the block, and their edges are detected in the system clock domain.

Top module: `ctl_serial_regs`

## Requirements
- R1: Each rising edge of `ser_clk` shifts one bit of `ser_data` into the word register at the least significant end. The first bit sent therefore ends up as bit 11, called B1, and the last bit sent ends up as bit 0, called B12.
- R2: Registers change only on a rising edge of `ser_latch`. Shifting bits without a latch edge leaves every output unchanged.
- R3: On a latch with B1 = 0, the attenuation register takes B2..B12, with B2 as its MSB. The mode flags keep their values.
- R4: On a latch with B1 = 1, the mode flags load from the word and the attenuation register keeps its value. B2..B5 are ignored. The flags map as follows: B6 to `test_sel_a`, B7 to `test_sel_b`, B8 to `rate_chk_slow`, B9 to `gain_boost`, B10 to `fs_sel_a`, B11 to `fs_sel_b`, B12 to `deemph_en`.
- R5: The deemphasis rate code on (`fs_sel_a`, `fs_sel_b`) is passed through unchanged. 00 means 44.1 kHz, 10 means 48 kHz and 01 means 32 kHz.
- R6: While `host_sel` is low, `deemph_en`, `fs_sel_a` and `fs_sel_b` follow `pin_deemph_en`, `pin_fs_a` and `pin_fs_b`, and `atten_level` reads 0x400. The stored register values reappear on these outputs when `host_sel` returns high.
- R7: During and after reset, all mode flags are 0 and the attenuation register is 0x400.
- R8: A latch that arrives after fewer than 12 new bits commits the shift register as it stands. That value is the older bits shifted up, with the new bits below them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | High: deemphasis controls and attenuation come from the registers. Low: they come from the pins and unity gain |
| ser_data | input | 1 | Serial data line, asynchronous |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_latch | input | 1 | Serial latch strobe, asynchronous |
| pin_deemph_en | input | 1 | Direct-pin deemphasis enable |
| pin_fs_a | input | 1 | Direct-pin deemphasis rate bit A |
| pin_fs_b | input | 1 | Direct-pin deemphasis rate bit B |
| atten_level | output | 11 | Attenuation level, where 0x400 is unity |
| test_sel_a | output | 1 | Test select A flag |
| test_sel_b | output | 1 | Test select B flag |
| rate_chk_slow | output | 1 | Ratio-check rate flag |
| gain_boost | output | 1 | +12 dB gain shift flag |
| fs_sel_a | output | 1 | Deemphasis rate code bit A |
| fs_sel_b | output | 1 | Deemphasis rate code bit B |
| deemph_en | output | 1 | Deemphasis enable |

## Verification
The bench builds the block with its defaults: a 12-bit word, an 11-bit attenuation field, two synchroniser stages and a 0x400 unity level. With two stages, a serial edge takes effect three system clocks after it arrives. Serial half-periods of four system clocks are therefore enough to exercise every ordering of data, clock and latch. The 11-bit field width makes both extremes, 0x001 and 0x7FF, reachable. It also lets a word with B1 set prove that the attenuation value survives a mode write.

// File: rtl/ctl_serial_pkg.sv
package ctl_serial_pkg;
   localparam int MODE_W = 7;

   typedef struct packed {
      logic test_a;
      logic test_b;
      logic rate_slow;
      logic boost;
      logic fs_a;
      logic fs_b;
      logic deemph;
   } mode_flags_t;
endpackage

// File: rtl/ser_edge_sync.sv
module ser_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic level,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ser_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= async_in;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev <= 1'b0;
      else        prev <= chain[STAGES-1];

   assign level = chain[STAGES-1];
   assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/ser_shift_in.sv
module ser_shift_in #(
   parameter int WORD_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic [WORD_W-1:0] word
);
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        word <= '0;
      else if (shift_en) word <= {word[WORD_W-2:0], bit_in};
endmodule

// File: rtl/ser_reg_bank.sv
module ser_reg_bank
   import ctl_serial_pkg::*;
#(
   parameter int          WORD_W    = 12,
   parameter int          ATT_W     = 11,
   parameter logic [10:0] ATT_UNITY = 11'h400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word,
   output logic [ATT_W-1:0]  atten_q,
   output mode_flags_t       flags_q
);
   localparam int SEL_BIT = WORD_W - 1;

   wire to_mode = word[SEL_BIT];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                 atten_q <= ATT_W'(ATT_UNITY);
      else if (load && !to_mode)  atten_q <= word[ATT_W-1:0];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                 flags_q <= '0;
      else if (load && to_mode)   flags_q <= mode_flags_t'(word[MODE_W-1:0]);
endmodule

// File: rtl/ctl_serial_regs.sv
module ctl_serial_regs
   import ctl_serial_pkg::*;
#(
   parameter int          WORD_W      = 12,
   parameter int          ATT_W       = 11,
   parameter int          SYNC_STAGES = 2,
   parameter logic [10:0] ATT_UNITY   = 11'h400
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_sel,
   input  logic             ser_data,
   input  logic             ser_clk,
   input  logic             ser_latch,
   input  logic             pin_deemph_en,
   input  logic             pin_fs_a,
   input  logic             pin_fs_b,
   output logic [ATT_W-1:0] atten_level,
   output logic             test_sel_a,
   output logic             test_sel_b,
   output logic             rate_chk_slow,
   output logic             gain_boost,
   output logic             fs_sel_a,
   output logic             fs_sel_b,
   output logic             deemph_en
);
   if (ATT_W != WORD_W - 1) begin : g_bad_att
      $error("ctl_serial_regs: ATT_W must equal WORD_W-1");
   end
   if (WORD_W < MODE_W + 1) begin : g_bad_word
      $error("ctl_serial_regs: WORD_W too small for mode flags");
   end

   logic              data_s, data_rise_unused;
   logic              clk_s, clk_rise;
   logic              lat_s, latch_rise;
   logic [WORD_W-1:0] shift_word;
   logic [ATT_W-1:0]  atten_q;
   mode_flags_t       flags_q;

   ser_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_data (
      .clk(clk), .rst_n(rst_n), .async_in(ser_data),
      .level(data_s), .rise(data_rise_unused));
   ser_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .async_in(ser_clk),
      .level(clk_s), .rise(clk_rise));
   ser_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_lat (
      .clk(clk), .rst_n(rst_n), .async_in(ser_latch),
      .level(lat_s), .rise(latch_rise));

   ser_shift_in #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .shift_en(clk_rise),
      .bit_in(data_s), .word(shift_word));

   ser_reg_bank #(.WORD_W(WORD_W), .ATT_W(ATT_W), .ATT_UNITY(ATT_UNITY)) u_bank (
      .clk(clk), .rst_n(rst_n), .load(latch_rise),
      .word(shift_word), .atten_q(atten_q), .flags_q(flags_q));

   always_comb begin
      test_sel_a    = flags_q.test_a;
      test_sel_b    = flags_q.test_b;
      rate_chk_slow = flags_q.rate_slow;
      gain_boost    = flags_q.boost;
      if (host_sel) begin
         atten_level = atten_q;
         deemph_en   = flags_q.deemph;
         fs_sel_a    = flags_q.fs_a;
         fs_sel_b    = flags_q.fs_b;
      end else begin
         atten_level = ATT_W'(ATT_UNITY);
         deemph_en   = pin_deemph_en;
         fs_sel_a    = pin_fs_a;
         fs_sel_b    = pin_fs_b;
      end
   end

   wire unused_ok = &{1'b0, clk_s, lat_s, data_rise_unused};
endmodule

// File: rtl/ctl_serial_regs_chk.sv
module ctl_serial_regs_chk #(
   parameter int WORD_W = 12,
   parameter int ATT_W  = 11,
   parameter int MODE_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clk_rise,
   input logic              latch_rise,
   input logic              data_s,
   input logic [WORD_W-1:0] shift_word,
   input logic [ATT_W-1:0]  atten_q,
   input logic [MODE_W-1:0] flags_q
);
   a_r1_shift_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
      clk_rise |=> (shift_word[0] == $past(data_s)) &&
                   (shift_word[WORD_W-1:1] == $past(shift_word[WORD_W-2:0])));

   a_r2_hold_without_latch: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_rise |=> $stable(atten_q) && $stable(flags_q));

   a_r3_atten_load: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_rise && !shift_word[WORD_W-1]) |=>
         (atten_q == $past(shift_word[ATT_W-1:0])) && $stable(flags_q));

   a_r4_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_rise && shift_word[WORD_W-1]) |=>
         (flags_q == $past(shift_word[MODE_W-1:0])) && $stable(atten_q));
endmodule

bind ctl_serial_regs ctl_serial_regs_chk #(
   .WORD_W(WORD_W), .ATT_W(ATT_W), .MODE_W(ctl_serial_pkg::MODE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .clk_rise(clk_rise), .latch_rise(latch_rise),
   .data_s(data_s), .shift_word(shift_word), .atten_q(atten_q),
   .flags_q(flags_q)
);

// File: tb/sim_ctl_serial_regs.sv
`timescale 1ns/1ps
module sim_ctl_serial_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_sel = 1'b1;
   logic        ser_data = 1'b0, ser_clk = 1'b0, ser_latch = 1'b0;
   logic        pin_deemph_en = 1'b0, pin_fs_a = 1'b0, pin_fs_b = 1'b0;
   logic [10:0] atten_level;
   logic        test_sel_a, test_sel_b, rate_chk_slow, gain_boost;
   logic        fs_sel_a, fs_sel_b, deemph_en;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ctl_serial_regs u0 (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel),
      .ser_data(ser_data), .ser_clk(ser_clk), .ser_latch(ser_latch),
      .pin_deemph_en(pin_deemph_en), .pin_fs_a(pin_fs_a), .pin_fs_b(pin_fs_b),
      .atten_level(atten_level), .test_sel_a(test_sel_a), .test_sel_b(test_sel_b),
      .rate_chk_slow(rate_chk_slow), .gain_boost(gain_boost),
      .fs_sel_a(fs_sel_a), .fs_sel_b(fs_sel_b), .deemph_en(deemph_en));

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // flags in the order test_a,test_b,rate,boost,fs_a,fs_b,deemph
   function automatic logic [6:0] flags_now();
      return {test_sel_a, test_sel_b, rate_chk_slow, gain_boost,
              fs_sel_a, fs_sel_b, deemph_en};
   endfunction

   task automatic send_bits(input logic [11:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         ser_data = v[i];
         wait_clks(3);
         ser_clk = 1'b1;
         wait_clks(4);
         ser_clk = 1'b0;
         wait_clks(3);
      end
   endtask

   task automatic pulse_latch();
      ser_latch = 1'b1;
      wait_clks(5);
      ser_latch = 1'b0;
      wait_clks(4);
   endtask

   task automatic write_word(input logic [11:0] w);
      send_bits(w, 12);
      pulse_latch();
   endtask

   task automatic t_reset_state();
      check("R7 atten after reset", 32'(atten_level), 32'h400);
      check("R7 flags after reset", 32'(flags_now()), 32'h0);
   endtask

   task automatic t_atten_writes();
      write_word(12'h001);
      check("R3 R1 atten min step", 32'(atten_level), 32'h001);
      check("R3 flags untouched", 32'(flags_now()), 32'h0);
      write_word(12'h7FF);
      check("R3 atten max", 32'(atten_level), 32'h7FF);
      write_word(12'h2A5);
      check("R1 R3 msb-first order", 32'(atten_level), 32'h2A5);
   endtask

   task automatic t_mode_write();
      // B2..B5 all ones must be ignored
      write_word(12'hFDA);
      check("R4 flag mapping", 32'(flags_now()), 32'h5A);
      check("R4 atten kept", 32'(atten_level), 32'h2A5);
   endtask

   task automatic t_fs_codes();
      write_word(12'h804);
      check("R5 code 48k", 32'({fs_sel_a, fs_sel_b}), 32'h2);
      write_word(12'h802);
      check("R5 code 32k", 32'({fs_sel_a, fs_sel_b}), 32'h1);
      write_word(12'h801);
      check("R5 code 44.1k with enable", 32'({fs_sel_a, fs_sel_b, deemph_en}), 32'h1);
   endtask

   task automatic t_pin_select();
      pin_deemph_en = 1'b0; pin_fs_a = 1'b1; pin_fs_b = 1'b0;
      host_sel = 1'b0;
      wait_clks(2);
      check("R6 pins drive deemph", 32'({fs_sel_a, fs_sel_b, deemph_en}), 32'h4);
      check("R6 atten unity", 32'(atten_level), 32'h400);
      pin_deemph_en = 1'b1; pin_fs_a = 1'b0; pin_fs_b = 1'b1;
      wait_clks(2);
      check("R6 pins follow", 32'({fs_sel_a, fs_sel_b, deemph_en}), 32'h3);
      host_sel = 1'b1;
      wait_clks(2);
      check("R6 registers restored", 32'({fs_sel_a, fs_sel_b, deemph_en}), 32'h1);
   endtask

   task automatic t_no_latch();
      write_word(12'h123);
      send_bits(12'hA5C, 12);
      wait_clks(6);
      check("R2 atten held without latch", 32'(atten_level), 32'h123);
      check("R2 flags held without latch", 32'(flags_now()), 32'h01);
   endtask

   task automatic t_partial();
      // previous shifted word 0xA5C, four new bits 0011 -> 0x5C3
      send_bits(12'h003, 4);
      pulse_latch();
      check("R8 partial latch word", 32'(atten_level), 32'h5C3);
   endtask

   task automatic t_reset_again();
      rst_n = 1'b0;
      wait_clks(2);
      check("R7 atten during reset", 32'(atten_level), 32'h400);
      rst_n = 1'b1;
      wait_clks(2);
      check("R7 flags after second reset", 32'(flags_now()), 32'h0);
   endtask

   initial begin
      wait_clks(4);
      rst_n = 1'b1;
      wait_clks(2);
      t_reset_state();
      t_atten_writes();
      t_mode_write();
      t_fs_codes();
      t_pin_select();
      t_no_latch();
      t_partial();
      t_reset_again();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule